// File: doc/BRIEF.md
# Strided Burst Address Generator

This block walks a memory address forward from a start point in a grouped pattern. The first access uses the start address. Each step strobe then moves to the next address. Inside a group, successive accesses sit one access width apart. After the last access of a group, the following step also adds a programmed byte skip, and a new group begins. Three stride settings are available, and each one has its own skip size and group length. A start strobe chooses one of them.

The chip select region that contains the start address becomes the home region of the sequence. Any step that would leave the home region is rejected. The sequence then stops and a sticky error is raised. The error keeps the rejected address and a 4-bit code. The code carries the home chip select in bits 3:2 and the stride setting in bits 1:0. An interrupt line follows the error only while its enable input is high. Memory command issue is done elsewhere. This block only supplies the addresses.

Top module: `strided_addr_gen`

## Requirements
- R1: After reset, addr_o, valid_o, err_o, err_code_o, err_addr_o and irq_o are all zero.
- R2: A start strobe loads start_addr_i into addr_o one cycle later and clears the group position. valid_o rises if the address lies in an enabled chip select region and the stride select is 0, 1 or 2. The lowest-numbered matching region becomes home. Start takes precedence over a step strobe in the same cycle.
- R3: A start whose stride select is 3, or whose address matches no enabled region, leaves valid_o low.
- R4: A step taken while the group position is below the group count of the active stride adds ACC_BYTES (4) to the address and advances the group position by one.
- R5: A step taken while the group position equals the group count adds ACC_BYTES plus the 11-bit skip of the active stride, and resets the group position to zero. The group length is therefore the count plus one. Stride n holds its skip in cfg_skip_i[11n+10:11n] and its count in cfg_count_i[3n+2:3n].
- R6: A step while valid_o is low has no effect. A cycle with no strobe leaves addr_o and valid_o unchanged.
- R7: Address a lies in region k when cs_en_i[k] is 1 and (a[31:22] & mask_k) == (base_k & mask_k). Here base_k and mask_k are the 10-bit slices [10k+9:10k] of cs_base_i and cs_mask_i.
- R8: A step whose next address lies outside the home region does the following. It sets err_o and clears valid_o. It keeps addr_o at the last good address. It captures the rejected next address in err_addr_o.
- R9: On such an error, err_code_o becomes {home chip select[1:0], stride select[1:0]}.
- R10: err_o stays set until err_clr_i is high. A later error overwrites err_code_o and err_addr_o. An error and a clear in the same cycle leave err_o set.
- R11: irq_o is high exactly when err_o is high and irq_en_i was high at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new sequence |
| start_addr_i | input | 32 | First address of the sequence |
| stride_sel_i | input | 2 | Stride setting used by the sequence |
| step_i | input | 1 | Advance to the next address |
| cfg_skip_i | input | 33 | Byte skip per stride, 11 bits each |
| cfg_count_i | input | 9 | Group count per stride, 3 bits each |
| cs_base_i | input | 30 | Region base per chip select, 10 bits each |
| cs_mask_i | input | 30 | Region compare mask per chip select, 10 bits each |
| cs_en_i | input | 3 | Region enable per chip select |
| irq_en_i | input | 1 | Interrupt enable |
| err_clr_i | input | 1 | Clear the boundary error |
| addr_o | output | 32 | Current address |
| valid_o | output | 1 | Sequence active and addr_o usable |
| err_o | output | 1 | Sticky boundary error |
| err_code_o | output | 4 | Home chip select and stride of last error |
| err_addr_o | output | 32 | Rejected address of last error |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an error and a clear in the same cycle. The error can only come from a step that leaves the home region, so the bench first starts a linear stride one access below the top of a region. It then asserts the clear together with the step that crosses into the next region.

A second hard case is the skip step of the longest group pushing the address out of its region. To reach it, the bench starts a long group just under the top of a small region and steps through the whole group. A third hard case is an overwrite of an error that is still pending. For this, the bench raises a second error while the first one is still uncleared.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int CODE_HALF_W = 2;

  typedef enum logic {
    GRP_INNER = 1'b0,
    GRP_SKIP  = 1'b1
  } grp_step_e;
endpackage

// File: rtl/sag_cs_match.sv
module sag_cs_match #(
  parameter int ADDR_W = 32,
  parameter int CMP_W  = 10,
  parameter int NUM_CS = 3
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [NUM_CS*CMP_W-1:0] base_i,
  input  logic [NUM_CS*CMP_W-1:0] mask_i,
  input  logic [NUM_CS-1:0]       en_i,
  output logic [NUM_CS-1:0]       hit_o
);
  logic [CMP_W-1:0] upper;
  assign upper = addr_i[ADDR_W-1 -: CMP_W];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_region
    logic [CMP_W-1:0] msk;
    assign msk      = mask_i[g*CMP_W +: CMP_W];
    assign hit_o[g] = en_i[g] && ((upper & msk) == (base_i[g*CMP_W +: CMP_W] & msk));
  end
endmodule

// File: rtl/sag_advance.sv
module sag_advance
  import sag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFS_W      = 11,
  parameter int CNT_W      = 3,
  parameter int NUM_STRIDE = 3,
  parameter int SEL_W      = 2,
  parameter int ACC_BYTES  = 4
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [CNT_W-1:0]            grp_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [NUM_STRIDE*OFS_W-1:0] skip_cfg_i,
  input  logic [NUM_STRIDE*CNT_W-1:0] cnt_cfg_i,
  output logic [ADDR_W-1:0]           nxt_addr_o,
  output logic [CNT_W-1:0]            nxt_grp_o
);
  logic [OFS_W-1:0] skip_arr [NUM_STRIDE];
  logic [CNT_W-1:0] cnt_arr  [NUM_STRIDE];

  for (genvar s = 0; s < NUM_STRIDE; s++) begin : g_unpack
    assign skip_arr[s] = skip_cfg_i[s*OFS_W +: OFS_W];
    assign cnt_arr[s]  = cnt_cfg_i[s*CNT_W +: CNT_W];
  end

  grp_step_e        kind;
  logic [ADDR_W-1:0] extra;

  always_comb begin
    kind  = (grp_i == cnt_arr[sel_i]) ? GRP_SKIP : GRP_INNER;
    extra = '0;
    if (kind == GRP_SKIP) extra = {{(ADDR_W-OFS_W){1'b0}}, skip_arr[sel_i]};
    nxt_addr_o = addr_i + ADDR_W'(ACC_BYTES) + extra;
    nxt_grp_o  = (kind == GRP_SKIP) ? '0 : grp_i + CNT_W'(1);
  end
endmodule

// File: rtl/sag_err_capture.sv
module sag_err_capture #(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              irq_en_i,
  output logic              err_o,
  output logic [CODE_W-1:0] code_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              irq_o
);
  logic err_n;

  always_comb begin
    err_n = err_o;
    if (clr_i)  err_n = 1'b0;
    if (fire_i) err_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      err_o <= err_n;
      irq_o <= err_n & irq_en_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= '0;
      addr_o <= '0;
    end else if (fire_i) begin
      code_o <= code_i;
      addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/strided_addr_gen.sv
module strided_addr_gen
  import sag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFS_W      = 11,
  parameter int CNT_W      = 3,
  parameter int NUM_STRIDE = 3,
  parameter int NUM_CS     = 3,
  parameter int CMP_W      = 10,
  parameter int ACC_BYTES  = 4,
  localparam int SEL_W     = CODE_HALF_W,
  localparam int IDX_W     = CODE_HALF_W,
  localparam int CODE_W    = IDX_W + SEL_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [ADDR_W-1:0]           start_addr_i,
  input  logic [SEL_W-1:0]            stride_sel_i,
  input  logic                        step_i,
  input  logic [NUM_STRIDE*OFS_W-1:0] cfg_skip_i,
  input  logic [NUM_STRIDE*CNT_W-1:0] cfg_count_i,
  input  logic [NUM_CS*CMP_W-1:0]     cs_base_i,
  input  logic [NUM_CS*CMP_W-1:0]     cs_mask_i,
  input  logic [NUM_CS-1:0]           cs_en_i,
  input  logic                        irq_en_i,
  input  logic                        err_clr_i,
  output logic [ADDR_W-1:0]           addr_o,
  output logic                        valid_o,
  output logic                        err_o,
  output logic [CODE_W-1:0]           err_code_o,
  output logic [ADDR_W-1:0]           err_addr_o,
  output logic                        irq_o
);
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_STRIDE - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              valid_q, valid_n;
  logic [CNT_W-1:0]  grp_q, grp_n;
  logic [SEL_W-1:0]  sel_q, sel_n;
  logic [IDX_W-1:0]  home_q, home_n;

  logic [NUM_CS-1:0] start_hit, nxt_hit;
  logic [IDX_W-1:0]  start_idx;
  logic [ADDR_W-1:0] nxt_addr;
  logic [CNT_W-1:0]  nxt_grp;
  logic              fire;

  sag_cs_match #(.ADDR_W(ADDR_W), .CMP_W(CMP_W), .NUM_CS(NUM_CS)) u_start_match (
    .addr_i(start_addr_i), .base_i(cs_base_i), .mask_i(cs_mask_i),
    .en_i(cs_en_i), .hit_o(start_hit)
  );

  sag_cs_match #(.ADDR_W(ADDR_W), .CMP_W(CMP_W), .NUM_CS(NUM_CS)) u_next_match (
    .addr_i(nxt_addr), .base_i(cs_base_i), .mask_i(cs_mask_i),
    .en_i(cs_en_i), .hit_o(nxt_hit)
  );

  sag_advance #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .CNT_W(CNT_W),
    .NUM_STRIDE(NUM_STRIDE), .SEL_W(SEL_W), .ACC_BYTES(ACC_BYTES)
  ) u_advance (
    .addr_i(addr_q), .grp_i(grp_q), .sel_i(sel_q),
    .skip_cfg_i(cfg_skip_i), .cnt_cfg_i(cfg_count_i),
    .nxt_addr_o(nxt_addr), .nxt_grp_o(nxt_grp)
  );

  // lowest-numbered matching region wins
  always_comb begin
    start_idx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (start_hit[i]) start_idx = IDX_W'(i);
    end
  end

  always_comb begin
    addr_n  = addr_q;
    valid_n = valid_q;
    grp_n   = grp_q;
    sel_n   = sel_q;
    home_n  = home_q;
    fire    = 1'b0;
    if (start_i) begin
      addr_n  = start_addr_i;
      grp_n   = '0;
      sel_n   = stride_sel_i;
      home_n  = start_idx;
      valid_n = (|start_hit) && (stride_sel_i <= SEL_MAX);
    end else if (step_i && valid_q) begin
      if (nxt_hit[home_q]) begin
        addr_n = nxt_addr;
        grp_n  = nxt_grp;
      end else begin
        valid_n = 1'b0;
        fire    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
      grp_q   <= '0;
      sel_q   <= '0;
      home_q  <= '0;
    end else begin
      addr_q  <= addr_n;
      valid_q <= valid_n;
      grp_q   <= grp_n;
      sel_q   <= sel_n;
      home_q  <= home_n;
    end
  end

  sag_err_capture #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_err (
    .clk(clk), .rst_n(rst_int_n), .fire_i(fire), .clr_i(err_clr_i),
    .code_i({home_q, sel_q}), .addr_i(nxt_addr), .irq_en_i(irq_en_i),
    .err_o(err_o), .code_o(err_code_o), .addr_o(err_addr_o), .irq_o(irq_o)
  );

  assign addr_o  = addr_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/sag_chk.sv
module sag_chk #(
  parameter int ADDR_W    = 32,
  parameter int CODE_W    = 4,
  parameter int ACC_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              step_i,
  input logic              err_clr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              valid_o,
  input logic              err_o,
  input logic [CODE_W-1:0] err_code_o,
  input logic [ADDR_W-1:0] err_addr_o,
  input logic              irq_o
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !step_i) |=> ($stable(addr_o) && $stable(valid_o))); // R6

  AST_NO_REVIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !start_i) |=> !valid_o); // R6

  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && step_i && !start_i) |=>
      (!valid_o || ((addr_o - $past(addr_o)) >= ADDR_W'(ACC_BYTES)))); // R4

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !valid_o); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !err_clr_i) |=> err_o); // R10

  AST_CAPTURE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> ($stable(err_addr_o) && $stable(err_code_o))); // R10

  AST_IRQ_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> err_o); // R11
endmodule

bind strided_addr_gen sag_chk #(
  .ADDR_W(ADDR_W), .CODE_W(CODE_W), .ACC_BYTES(ACC_BYTES)
) u_sag_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
  .err_clr_i(err_clr_i), .addr_o(addr_o), .valid_o(valid_o), .err_o(err_o),
  .err_code_o(err_code_o), .err_addr_o(err_addr_o), .irq_o(irq_o)
);

// File: tb/tb_strided_addr_gen.sv
`timescale 1ns/1ps
module tb_strided_addr_gen;
  localparam logic [29:0] CS_BASE  = {10'h008, 10'h004, 10'h000};
  localparam logic [29:0] CS_MASK  = {10'h3FF, 10'h3FC, 10'h3FC};
  localparam logic [32:0] SKIP_CFG = {11'h7FF, 11'h000, 11'h100};
  localparam logic [8:0]  CNT_CFG  = {3'd7, 3'd0, 3'd3};

  logic        clk, rst_n;
  logic        start_i, step_i, irq_en_i, err_clr_i;
  logic [31:0] start_addr_i;
  logic [1:0]  stride_sel_i;
  logic [2:0]  cs_en_i;
  logic [31:0] addr_o, err_addr_o;
  logic        valid_o, err_o, irq_o;
  logic [3:0]  err_code_o;

  strided_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .stride_sel_i(stride_sel_i), .step_i(step_i), .cfg_skip_i(SKIP_CFG),
    .cfg_count_i(CNT_CFG), .cs_base_i(CS_BASE), .cs_mask_i(CS_MASK),
    .cs_en_i(cs_en_i), .irq_en_i(irq_en_i), .err_clr_i(err_clr_i),
    .addr_o(addr_o), .valid_o(valid_o), .err_o(err_o), .err_code_o(err_code_o),
    .err_addr_o(err_addr_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [31:0] addr;
    logic        valid;
    logic        err;
    logic [3:0]  code;
    logic [31:0] eaddr;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // reference model state
  logic [31:0] m_addr = '0, m_eaddr = '0;
  logic        m_valid = 0, m_err = 0, m_irq = 0;
  logic [2:0]  m_grp = '0;
  logic [1:0]  m_sel = '0, m_home = '0;
  logic [3:0]  m_code = '0;

  function automatic bit in_cs(input logic [31:0] a, input int i);
    logic [9:0] m;
    m = CS_MASK[i*10 +: 10];
    return cs_en_i[i] && ((a[31:22] & m) == (CS_BASE[i*10 +: 10] & m));
  endfunction

  function automatic int home_of(input logic [31:0] a);
    for (int i = 0; i < 3; i++) if (in_cs(a, i)) return i;
    return -1;
  endfunction

  task automatic op(input bit st, input logic [31:0] a, input int s,
                    input bit stp, input bit clr, input string tag);
    int          h;
    bit          fire, skip;
    logic [31:0] n;
    exp_t        e;
    start_i = st; start_addr_i = a; stride_sel_i = 2'(s);
    step_i = stp; err_clr_i = clr;
    fire = 0;
    if (st) begin
      h = home_of(a);
      m_addr = a; m_grp = '0; m_sel = 2'(s);
      m_home = (h < 0) ? 2'd0 : 2'(h);
      m_valid = (h >= 0) && (s < 3);
    end else if (stp && m_valid) begin
      skip = (m_grp == CNT_CFG[m_sel*3 +: 3]);
      n = m_addr + 32'd4 + (skip ? {21'd0, SKIP_CFG[m_sel*11 +: 11]} : 32'd0);
      if (in_cs(n, int'(m_home))) begin
        m_addr = n;
        m_grp = skip ? 3'd0 : m_grp + 3'd1;
      end else begin
        m_valid = 0; fire = 1; m_eaddr = n; m_code = {m_home, m_sel};
      end
    end
    if (fire) m_err = 1;
    else if (clr) m_err = 0;
    m_irq = m_err & irq_en_i;
    e.addr = m_addr; e.valid = m_valid; e.err = m_err; e.code = m_code;
    e.eaddr = m_eaddr; e.irq = m_irq; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    start_i = 0; step_i = 0; err_clr_i = 0;
  endtask

  // monitor: compare one item after each active edge that follows a drive
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (addr_o !== e.addr || valid_o !== e.valid || err_o !== e.err ||
            err_code_o !== e.code || err_addr_o !== e.eaddr || irq_o !== e.irq) begin
          errors++;
          $display("FAIL %s: got addr=%h v=%b err=%b code=%h eaddr=%h irq=%b exp addr=%h v=%b err=%b code=%h eaddr=%h irq=%b",
                   e.tag, addr_o, valid_o, err_o, err_code_o, err_addr_o, irq_o,
                   e.addr, e.valid, e.err, e.code, e.eaddr, e.irq);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; step_i = 0; err_clr_i = 0; irq_en_i = 1;
    start_addr_i = '0; stride_sel_i = '0; cs_en_i = 3'b111;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    op(0, 0, 0, 0, 0, "R1 reset state");

    // grouped stride 0: 4 accesses per group, then +0x100 extra
    op(1, 32'h0000_1000, 0, 0, 0, "R2 start stride0");
    for (int i = 0; i < 3; i++) op(0, 0, 0, 1, 0, "R4 inner step");
    op(0, 0, 0, 1, 0, "R5 skip step");
    op(0, 0, 0, 1, 0, "R4 new group");
    op(0, 0, 0, 0, 0, "R6 hold without strobe");

    // stride 1: count 0, skip 0 -> linear
    op(1, 32'h0100_0000, 1, 0, 0, "R7 start in region1");
    op(0, 0, 0, 1, 0, "R5 single-access group");
    op(0, 0, 0, 1, 0, "R5 single-access group");

    // rejected starts and ignored steps
    op(1, 32'h0000_1000, 3, 0, 0, "R3 stride select 3");
    op(0, 0, 0, 1, 0, "R6 step while invalid");
    op(1, 32'h0300_0000, 0, 0, 0, "R3 unmapped start");
    op(0, 0, 0, 1, 0, "R6 step while invalid");
    cs_en_i = 3'b110;
    op(1, 32'h0000_1000, 0, 0, 0, "R7 disabled region");
    cs_en_i = 3'b111;

    // crossing out of region 0 on a skip step
    op(1, 32'h00FF_FFF0, 0, 0, 0, "R2 start near top");
    for (int i = 0; i < 3; i++) op(0, 0, 0, 1, 0, "R4 approach boundary");
    op(0, 0, 0, 1, 0, "R8 boundary crossed");
    op(0, 0, 0, 1, 0, "R6 step after halt");
    op(0, 0, 0, 0, 0, "R10 error sticky");
    op(1, 32'h0000_2000, 0, 0, 0, "R10 sticky across start");
    op(0, 0, 0, 1, 0, "R10 sticky across step");

    // long group in region 2 overruns on the skip step
    op(1, 32'h023F_FF00, 2, 0, 0, "R2 start region2 stride2");
    for (int i = 0; i < 9; i++) op(0, 0, 0, 1, 0, "R9 code home2 stride2");
    op(0, 0, 0, 0, 1, "R10 clear");

    // interrupt gating
    irq_en_i = 0;
    op(1, 32'h01FF_FFF8, 1, 0, 0, "R2 start region1");
    op(0, 0, 0, 1, 0, "R4 linear step");
    op(0, 0, 0, 1, 0, "R11 error with irq disabled");
    irq_en_i = 1;
    op(0, 0, 0, 0, 0, "R11 irq after enable");

    // error and clear together; later error overwrites capture
    op(1, 32'h00FF_FFFC, 1, 0, 0, "R2 start region0 stride1");
    op(0, 0, 0, 1, 1, "R10 error beats clear");

    // start wins over step
    op(1, 32'h0000_3000, 0, 1, 0, "R2 start beats step");
    op(0, 0, 0, 0, 1, "R10 final clear");

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule